// File: doc/BRIEF.md
# Binary-Field Inverter for GF(2^233)

This block returns the multiplicative inverse of a nonzero element of GF(2^233), with elements held in polynomial basis and reduced by the trinomial x^233 + x^74 + 1. It uses the Itoh-Tsujii method, which avoids running a long exponentiation one multiply at a time. A working value beta_k = a^(2^k - 1) is grown along a fixed chain of exponents that is derived, at elaboration, from the binary form of m - 1 = 232: 1, 2, 3, 6, 7, 14, 28, 29, 58, 116, 232. A doubling step computes beta_2k = (beta_k)^(2^k) * beta_k. The squarings run one per clock through a combinational squarer. An increment step computes beta_(k+1) = (beta_k)^2 * a. A final squaring of beta_232 gives the inverse.

All ten multiplications run one after another on a single bit-serial shift-and-add multiplier. That multiplier takes one bit of its multiplicand per clock and needs 233 clocks per product. The user raises `start` for one cycle with the operand on `operand`. The block then runs by itself and raises `done` for one cycle, with the inverse on `result`. The inverse of zero is not defined, and the block does not handle it.

The sequencer has six named states:
- IDLE waits for `start`.
- PREP copies beta into the squaring register and loads the squaring count: k for a doubling, 1 for an increment.
- SQUARE applies one squaring per clock until the count runs out.
- MUL_KICK starts the multiplier. The other factor is beta for a doubling and the captured operand for an increment.
- MUL_WAIT holds until the product is ready. It then stores the product as the new beta and moves to the next chain step, either back to PREP or, after the last step, to FINISH.
- FINISH squares beta into `result`, pulses `done` and returns to IDLE.

Top module: `gf_inverse`

## Requirements
- R1: After reset, `done` is 0 and `result` is all zeros.
- R2: For every nonzero operand a, the value on `result` when `done` pulses satisfies a * result = 1 in GF(2^233) modulo x^233 + x^74 + 1. It is therefore never zero.
- R3: For operand 1 (only bit 0 set), the result is 1.
- R4: For operand x (value 2, only bit 1 set), the result is x^232 + x^73 (bits 232 and 73 set, all others clear).
- R5: `done` is high for exactly one cycle per inversion. `result` changes only in the cycle in which `done` is high, and it holds its value afterwards until the next inversion completes.
- R6: The number of cycles from `start` to `done` is the same for every nonzero operand.
- R7: The operand is captured in the cycle in which `start` is accepted. While an inversion is running, further `start` pulses and changes on `operand` have no effect on the result or on its timing.
- R8: Only one multiplier exists, and it is never restarted while it is still busy. A complete inversion takes between 10*233 and 12*233 cycles, which is ten serial products plus at most 233 squarings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin an inversion (ignored while busy) |
| operand | input | 233 | Nonzero field element to invert, sampled with `start` |
| done | output | 1 | One-cycle pulse when `result` holds the new inverse |
| result | output | 233 | Inverse of the last accepted operand |

## Verification
The operands are pseudo-random 233-bit values, the all-ones element, and the two known-answer cases 1 and x. The random operands exercise every chain step with dense bit patterns and are checked through the product a * result = 1. The all-ones element stresses reduction from the top bit. The operand 1 shows that the chain ends on the identity. The operand x pins down the reduction trinomial itself: a wrong tap position would produce a different bit pair. One run pokes a second `start` and a different operand partway through an inversion, which shows whether the operand is captured and held. Latency is compared across all runs, which would expose any path that depends on the data.

// File: rtl/gf_inv_pkg.sv
package gf_inv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_SQUARE,
        ST_MUL_KICK,
        ST_MUL_WAIT,
        ST_FINISH
    } inv_state_e;

    typedef enum logic {
        STEP_DOUBLE,
        STEP_INCR
    } chain_step_e;

    // Position of the highest set bit of a positive value.
    function automatic int top_bit(input int v);
        int pos;
        pos = 0;
        for (int i = 0; i < 31; i++) begin
            if (((v >> i) & 1) == 1) pos = i;
        end
        return pos;
    endfunction

endpackage

// File: rtl/gf_square.sv
module gf_square #(
    parameter int M = 233,
    parameter int T = 74
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] y
);
    localparam int WW = 2 * M - 1;

    logic [WW-1:0] spread;

    always_comb begin
        spread = '0;
        for (int i = 0; i < M; i++) begin
            spread[2*i] = a[i];
        end
        // Fold each bit at or above x^M back using x^M = x^T + 1.
        for (int i = WW - 1; i >= M; i--) begin
            if (spread[i]) begin
                spread[i]         = 1'b0;
                spread[i - M + T] = ~spread[i - M + T];
                spread[i - M]     = ~spread[i - M];
            end
        end
        y = spread[M-1:0];
    end

endmodule

// File: rtl/gf_mul_serial.sv
module gf_mul_serial #(
    parameter int M = 233,
    parameter int T = 74
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [M-1:0] p
);
    localparam int CW = $clog2(M + 1);
    localparam logic [M-1:0] RED = (M'(1) << T) | M'(1);

    logic [M-1:0]  acc;
    logic [M-1:0]  a_q;
    logic [M-1:0]  b_q;
    logic [CW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            a_q  <= '0;
            b_q  <= '0;
            left <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                acc  <= '0;
                a_q  <= a;
                b_q  <= b;
                left <= CW'(M);
                busy <= 1'b1;
            end else if (busy) begin
                // Horner step, most significant multiplicand bit first.
                acc  <= {acc[M-2:0], 1'b0} ^ (acc[M-1] ? RED : '0)
                        ^ (b_q[M-1] ? a_q : '0);
                b_q  <= {b_q[M-2:0], 1'b0};
                left <= left - 1'b1;
                if (left == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign p = acc;

endmodule

// File: rtl/gf_inv_seq.sv
module gf_inv_seq
    import gf_inv_pkg::*;
#(
    parameter int M = 233
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] operand,
    output logic         done,
    output logic [M-1:0] result,
    output logic         busy,
    output logic [M-1:0] op_held,
    output logic [M-1:0] sq_in,
    input  logic [M-1:0] sq_out,
    output logic         mul_start,
    output logic [M-1:0] mul_a,
    output logic [M-1:0] mul_b,
    input  logic         mul_done,
    input  logic [M-1:0] mul_p
);
    localparam int KW = $clog2(M);
    localparam int IW = (KW > 1) ? $clog2(KW) : 1;
    localparam logic [KW-1:0] CHAIN = KW'(M - 1);
    localparam int TOP = top_bit(M - 1);
    localparam logic [IW-1:0] IDX_FIRST = IW'(TOP - 1);

    inv_state_e  state, state_n;
    chain_step_e step;
    logic [M-1:0]  beta;
    logic [M-1:0]  work;
    logic [M-1:0]  a_cap;
    logic [KW-1:0] k_cur;
    logic [KW-1:0] sq_left;
    logic [IW-1:0] idx;
    logic          last_step;

    assign last_step = (idx == '0) &&
                       ((step == STEP_INCR) || !CHAIN[idx]);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Transitions.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:     if (start) state_n = ST_PREP;
            ST_PREP:     state_n = ST_SQUARE;
            ST_SQUARE:   if (sq_left == KW'(1)) state_n = ST_MUL_KICK;
            ST_MUL_KICK: state_n = ST_MUL_WAIT;
            ST_MUL_WAIT: if (mul_done) state_n = last_step ? ST_FINISH : ST_PREP;
            ST_FINISH:   state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    // Datapath and outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beta    <= '0;
            work    <= '0;
            a_cap   <= '0;
            k_cur   <= '0;
            sq_left <= '0;
            idx     <= '0;
            step    <= STEP_DOUBLE;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        a_cap <= operand;
                        beta  <= operand;
                        k_cur <= KW'(1);
                        idx   <= IDX_FIRST;
                        step  <= STEP_DOUBLE;
                    end
                end
                ST_PREP: begin
                    work    <= beta;
                    sq_left <= (step == STEP_DOUBLE) ? k_cur : KW'(1);
                end
                ST_SQUARE: begin
                    work    <= sq_out;
                    sq_left <= sq_left - 1'b1;
                end
                ST_MUL_KICK: begin
                end
                ST_MUL_WAIT: begin
                    if (mul_done) begin
                        beta <= mul_p;
                        if (step == STEP_DOUBLE) begin
                            k_cur <= k_cur << 1;
                            if (CHAIN[idx]) begin
                                step <= STEP_INCR;
                            end else begin
                                idx <= idx - 1'b1;
                            end
                        end else begin
                            k_cur <= k_cur + 1'b1;
                            step  <= STEP_DOUBLE;
                            idx   <= idx - 1'b1;
                        end
                    end
                end
                ST_FINISH: begin
                    result <= sq_out;
                    done   <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    assign sq_in     = (state == ST_FINISH) ? beta : work;
    assign mul_start = (state == ST_MUL_KICK);
    assign mul_a     = work;
    assign mul_b     = (step == STEP_DOUBLE) ? beta : a_cap;
    assign busy      = (state != ST_IDLE);
    assign op_held   = a_cap;

endmodule

// File: rtl/gf_inverse.sv
module gf_inverse #(
    parameter int M = 233,
    parameter int T = 74
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] operand,
    output logic         done,
    output logic [M-1:0] result
);
    logic         seq_busy;
    logic [M-1:0] op_held;
    logic [M-1:0] sq_in;
    logic [M-1:0] sq_out;
    logic         mul_start;
    logic [M-1:0] mul_a;
    logic [M-1:0] mul_b;
    logic         mul_busy;
    logic         mul_done;
    logic [M-1:0] mul_p;

    gf_inv_seq #(.M(M)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .operand   (operand),
        .done      (done),
        .result    (result),
        .busy      (seq_busy),
        .op_held   (op_held),
        .sq_in     (sq_in),
        .sq_out    (sq_out),
        .mul_start (mul_start),
        .mul_a     (mul_a),
        .mul_b     (mul_b),
        .mul_done  (mul_done),
        .mul_p     (mul_p)
    );

    gf_square #(.M(M), .T(T)) u_sq (
        .a (sq_in),
        .y (sq_out)
    );

    gf_mul_serial #(.M(M), .T(T)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .a     (mul_a),
        .b     (mul_b),
        .busy  (mul_busy),
        .done  (mul_done),
        .p     (mul_p)
    );

endmodule

// File: rtl/gf_inverse_chk.sv
module gf_inverse_chk #(
    parameter int M = 233
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic [M-1:0] result,
    input logic         seq_busy,
    input logic [M-1:0] op_held,
    input logic         mul_start,
    input logic         mul_busy
);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    assert_result_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != '0));

    assert_unit_inverse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_held == M'(1)) |-> (result == M'(1)));

    assert_single_mul_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |-> !mul_busy);

    assert_operand_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && $past(seq_busy)) |-> $stable(op_held));

    assert_start_no_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && start && !done) |=> (seq_busy || done));

endmodule

bind gf_inverse gf_inverse_chk #(.M(M)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .result    (result),
    .seq_busy  (seq_busy),
    .op_held   (op_held),
    .mul_start (mul_start),
    .mul_busy  (mul_busy)
);

// File: tb/tb_gf_inverse.sv
module tb_gf_inverse;
    localparam int M = 233;
    localparam int T = 74;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_LIMIT = 6000;
    localparam int NSEED = 8;
    localparam logic [63:0] SEEDS [0:NSEED-1] = '{
        64'h9E37_79B9_7F4A_7C15, 64'h0123_4567_89AB_CDEF,
        64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_0001,
        64'h8000_0000_0000_0000, 64'h5555_AAAA_3333_CCCC,
        64'hF0E1_D2C3_B4A5_9687, 64'h1357_9BDF_2468_ACE0
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] operand = '0;
    logic         done;
    logic [M-1:0] result;

    int total = 0;
    int bad = 0;
    int ref_lat = -1;

    gf_inverse #(.M(M), .T(T)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .operand (operand),
        .done    (done),
        .result  (result)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Schoolbook product, reduced by repeated folding of the high part.
    function automatic logic [M-1:0] fmul(input logic [M-1:0] x, input logic [M-1:0] y);
        logic [2*M-1:0] prod;
        logic [2*M-1:0] hi;
        logic [2*M-1:0] lowmask;
        prod = '0;
        lowmask = (2*M)'({M{1'b1}});
        for (int i = 0; i < M; i++) begin
            if (y[i]) prod = prod ^ ((2*M)'(x) << i);
        end
        for (int r = 0; r < 8; r++) begin
            hi = prod >> M;
            prod = (prod & lowmask) ^ hi ^ (hi << T);
        end
        return prod[M-1:0];
    endfunction

    function automatic logic [M-1:0] expand(input logic [63:0] seed);
        logic [63:0] s;
        logic [255:0] w;
        s = seed;
        w = '0;
        for (int i = 0; i < 4; i++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 7);
            s = s ^ (s << 17);
            w = {w[191:0], s};
        end
        if (w[M-1:0] == '0) return M'(1);
        return w[M-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [M-1:0] act, input logic [M-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_int(input bit ok, input string req, input string what,
                             input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One inversion; optionally pokes a second start with junk mid-run.
    task automatic run_inv(input logic [M-1:0] op, input bit poke,
                           output logic [M-1:0] res, output int lat);
        @(negedge clk);
        operand = op;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < RUN_LIMIT) begin
            if (poke && lat == 5) begin
                operand = ~op;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        res = result;
        if (lat >= RUN_LIMIT) begin
            total++;
            bad++;
            $display("FAIL R6 run timeout: actual=%0d expected=<%0d", lat, RUN_LIMIT);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [M-1:0] op;
        logic [M-1:0] res;
        logic [M-1:0] held;
        int lat;
        bit stable;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1", "done after reset", M'(done), M'(0));
        check(result == '0, "R1", "result after reset", result, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table walk: R2 product, R6 equal latency, R8 bounds
        for (int v = 0; v < NSEED; v++) begin
            op = expand(SEEDS[v]);
            run_inv(op, 1'b0, res, lat);
            check(fmul(op, res) == M'(1), "R2", "a*inverse", fmul(op, res), M'(1));
            if (ref_lat < 0) begin
                ref_lat = lat;
                check_int(lat >= 10 * M && lat <= 12 * M, "R8", "latency bound", lat, 11 * M);
            end
            check_int(lat == ref_lat, "R6", "latency equal", lat, ref_lat);
        end

        // R2: all-ones element
        op = '1;
        run_inv(op, 1'b0, res, lat);
        check(fmul(op, res) == M'(1), "R2", "all-ones a*inverse", fmul(op, res), M'(1));
        check_int(lat == ref_lat, "R6", "all-ones latency", lat, ref_lat);

        // R3: inverse of one
        run_inv(M'(1), 1'b0, res, lat);
        check(res == M'(1), "R3", "inverse of 1", res, M'(1));

        // R4: inverse of x is x^232 + x^73
        op = M'(2);
        run_inv(op, 1'b0, res, lat);
        held = (M'(1) << 232) | (M'(1) << 73);
        check(res == held, "R4", "inverse of x", res, held);

        // R5: done lasts one cycle, result holds
        @(negedge clk);
        check(done == 1'b0, "R5", "done one cycle", M'(done), M'(0));
        stable = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (result != held || done) stable = 1'b0;
        end
        check(stable, "R5", "result held idle", result, held);

        // R7: mid-run start and operand change ignored
        op = expand(64'h0F0F_1234_5678_9ABC);
        run_inv(op, 1'b1, res, lat);
        check(fmul(op, res) == M'(1), "R7", "captured operand kept", fmul(op, res), M'(1));
        check_int(lat == ref_lat, "R7", "latency unchanged", lat, ref_lat);
        @(negedge clk);
        check(done == 1'b0, "R7", "no second done", M'(done), M'(0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule